// File: doc/BRIEF.md
# Pointer Addressing Unit for Data-Memory Loads and Stores

This unit forms the data address for every load or store that goes through one of three 16-bit pointer registers, or that carries a full 16-bit address in the instruction word. The pointer values come from the register file, which is outside this block. The unit picks one pointer, applies the requested addressing mode, and drives the memory address. When the mode changes the pointer, the unit also returns the new pointer value with a write-back strobe.

Five modes are available: plain indirect, post-increment, pre-decrement, base-plus-displacement and direct. Displacement mode adds an unsigned 6-bit offset to the pointer and is allowed only with the second and third pointers. Loads and stores use the same path. A store flag travels with the request and comes out as the memory write enable.

Each accepted request takes two cycles. In the first cycle the memory strobe and the address are driven. In the second cycle the completion pulse, the illegal flag and any pointer write-back are driven. A new request can be accepted in the completion cycle, so accesses can run back to back.

Top module: `lsu_ptr_agu`

## Requirements
- R1: After reset, req_ready is 1 and mem_strobe, done, illegal and wb_strobe are 0.
- R2: Mode code 0 (indirect) addresses memory at the selected pointer (select code 0, 1, 2 = first, second, third pointer). wb_strobe stays 0.
- R3: Mode code 1 (post-increment) addresses memory at the old pointer value. wb_strobe is 1 and wb_value is the pointer plus 1.
- R4: Mode code 2 (pre-decrement) addresses memory at the pointer minus 1. wb_strobe is 1 and wb_value is that same reduced value.
- R5: Mode code 3 (displacement) with select code 1 or 2 addresses memory at the pointer plus the zero-extended 6-bit req_disp (0 to 63). wb_strobe stays 0.
- R6: Mode code 4 (direct) addresses memory at req_direct and ignores req_ptr_sel, including select code 3. wb_strobe stays 0.
- R7: A request is illegal if it uses mode code 3 with select code 0, a pointer mode (codes 0 to 3) with select code 3, or a mode code from 5 to 7. An illegal request raises illegal together with done. It drives no mem_strobe and no wb_strobe.
- R8: All pointer arithmetic wraps modulo 2^16: 0xFFFF+1 gives 0, 0x0000-1 gives 0xFFFF, and 0xFFFF+63 gives 0x003E.
- R9: For a legal request accepted at clock edge k, mem_strobe is 1 with mem_addr between edges k and k+1. done is 1 between edges k+1 and k+2. Each access therefore takes two cycles.
- R10: While mem_strobe is asserted, req_ready is 0 and req_valid is ignored. A request is accepted in the completion cycle, giving back-to-back accesses.
- R11: mem_write equals the req_store of the request during its address cycle. The address does not depend on req_store.
- R12: During a write-back, wb_sel equals the select code of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_ptr_sel | input | 2 | Pointer select: 0, 1, 2 = first, second, third; 3 = none |
| req_mode | input | 3 | Addressing mode code (0 to 4 legal) |
| req_disp | input | 6 | Unsigned displacement |
| req_direct | input | 16 | Direct address from the instruction |
| ptr_x | input | 16 | First pointer value |
| ptr_y | input | 16 | Second pointer value |
| ptr_z | input | 16 | Third pointer value |
| req_ready | output | 1 | Request can be accepted this cycle |
| mem_strobe | output | 1 | Memory access cycle |
| mem_write | output | 1 | Memory write enable during the access |
| mem_addr | output | 16 | Effective data address |
| done | output | 1 | Completion cycle of a request |
| illegal | output | 1 | Request was illegal (with done) |
| wb_strobe | output | 1 | Pointer write-back enable |
| wb_sel | output | 2 | Pointer to write back |
| wb_value | output | 16 | Updated pointer value |

## Verification
The bench targets the ends of the 16-bit range. If increment, decrement or displacement addition does not wrap, the bench sees an address or write-back value of the wrong width or value at 0xFFFF and 0x0000. It confirms that the post-increment address is the old pointer and that pre-decrement uses the reduced value. A design that swaps these two orders gives addresses one off. Displacement with the first pointer, unused select codes and spare mode codes are checked. A design that lets any of them through would strobe memory or corrupt a pointer. The bench also holds req_valid high through the address cycle and sends back-to-back requests. A sequencer that accepts too early or drops the completion-cycle accept shifts the strobe and done pulses out of their cycles.

// File: rtl/lsu_agu_pkg.sv
package lsu_agu_pkg;

  // Addressing mode encodings seen on req_mode
  typedef enum logic [2:0] {
    AM_IND     = 3'd0,
    AM_POSTINC = 3'd1,
    AM_PREDEC  = 3'd2,
    AM_DISP    = 3'd3,
    AM_DIRECT  = 3'd4
  } agu_mode_e;

  // Request life-cycle phases
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DONE = 2'd2
  } agu_phase_e;

  // Pointer that may not be used with a displacement
  localparam int unsigned NO_DISP_PTR = 0;

endpackage

// File: rtl/agu_ptr_select.sv
module agu_ptr_select #(
  parameter int unsigned AW    = 16,
  parameter int unsigned NPTR  = 3,
  parameter int unsigned SEL_W = 2
) (
  input  logic [NPTR-1:0][AW-1:0] ptrs,
  input  logic [SEL_W-1:0]        sel,
  output logic [AW-1:0]           value,
  output logic                    sel_ok
);

  logic [NPTR-1:0][AW-1:0] masked;

  // One AND term per pointer; the OR below merges them
  generate
    for (genvar g = 0; g < NPTR; g++) begin : g_term
      assign masked[g] = (sel == SEL_W'(g)) ? ptrs[g] : '0;
    end
  endgenerate

  always_comb begin
    value = '0;
    for (int i = 0; i < NPTR; i++) value = value | masked[i];
  end

  assign sel_ok = (32'(sel) < NPTR);

endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
  import lsu_agu_pkg::*;
#(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 6,
  parameter int unsigned SEL_W = 2
) (
  input  logic [2:0]       mode,
  input  logic [SEL_W-1:0] sel,
  input  logic             sel_ok,
  input  logic [AW-1:0]    ptr,
  input  logic [DW-1:0]    disp,
  input  logic [AW-1:0]    direct,
  output logic [AW-1:0]    addr,
  output logic [AW-1:0]    wb_value,
  output logic             wb_en,
  output logic             bad
);

  // Arithmetic kept in functions; all results wrap at AW bits
  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return p + AW'(1);
  endfunction

  function automatic logic [AW-1:0] ptr_dec(input logic [AW-1:0] p);
    return p - AW'(1);
  endfunction

  function automatic logic [AW-1:0] ptr_offs(input logic [AW-1:0] p,
                                             input logic [DW-1:0] q);
    return p + {{(AW-DW){1'b0}}, q};
  endfunction

  logic disp_on_x;
  assign disp_on_x = (sel == SEL_W'(NO_DISP_PTR));

  always_comb begin
    addr     = ptr;
    wb_value = ptr;
    wb_en    = 1'b0;
    bad      = 1'b0;
    case (mode)
      AM_IND: begin
        bad = !sel_ok;
      end
      AM_POSTINC: begin
        wb_value = ptr_inc(ptr);
        wb_en    = 1'b1;
        bad      = !sel_ok;
      end
      AM_PREDEC: begin
        addr     = ptr_dec(ptr);
        wb_value = ptr_dec(ptr);
        wb_en    = 1'b1;
        bad      = !sel_ok;
      end
      AM_DISP: begin
        addr = ptr_offs(ptr, disp);
        bad  = !sel_ok || disp_on_x;
      end
      AM_DIRECT: begin
        addr = direct;
      end
      default: begin
        bad = 1'b1;
      end
    endcase
    if (bad) wb_en = 1'b0;
  end

endmodule

// File: rtl/agu_sequencer.sv
module agu_sequencer
  import lsu_agu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic accept,
  output logic in_addr,
  output logic in_done
);

  agu_phase_e phase_q, phase_d;

  assign req_ready = (phase_q != PH_ADDR);
  assign accept    = req_valid && req_ready;
  assign in_addr   = (phase_q == PH_ADDR);
  assign in_done   = (phase_q == PH_DONE);

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE: if (accept) phase_d = PH_ADDR;
      PH_ADDR: phase_d = PH_DONE;
      PH_DONE: phase_d = accept ? PH_ADDR : PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

endmodule

// File: rtl/lsu_ptr_agu.sv
module lsu_ptr_agu #(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 6,
  parameter int unsigned NPTR  = 3,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic [SEL_W-1:0] req_ptr_sel,
  input  logic [2:0]       req_mode,
  input  logic [DW-1:0]    req_disp,
  input  logic [AW-1:0]    req_direct,
  input  logic [AW-1:0]    ptr_x,
  input  logic [AW-1:0]    ptr_y,
  input  logic [AW-1:0]    ptr_z,
  output logic             req_ready,
  output logic             mem_strobe,
  output logic             mem_write,
  output logic [AW-1:0]    mem_addr,
  output logic             done,
  output logic             illegal,
  output logic             wb_strobe,
  output logic [SEL_W-1:0] wb_sel,
  output logic [AW-1:0]    wb_value
);

  logic [NPTR-1:0][AW-1:0] ptr_bank;
  logic [AW-1:0]           ptr_val;
  logic                    sel_ok;
  logic [AW-1:0]           calc_addr, calc_wbv;
  logic                    calc_wb, calc_bad;
  logic                    accept, in_addr, in_done;

  assign ptr_bank = {ptr_z, ptr_y, ptr_x};

  agu_ptr_select #(.AW(AW), .NPTR(NPTR), .SEL_W(SEL_W)) u_sel (
    .ptrs   (ptr_bank),
    .sel    (req_ptr_sel),
    .value  (ptr_val),
    .sel_ok (sel_ok)
  );

  agu_addr_calc #(.AW(AW), .DW(DW), .SEL_W(SEL_W)) u_calc (
    .mode     (req_mode),
    .sel      (req_ptr_sel),
    .sel_ok   (sel_ok),
    .ptr      (ptr_val),
    .disp     (req_disp),
    .direct   (req_direct),
    .addr     (calc_addr),
    .wb_value (calc_wbv),
    .wb_en    (calc_wb),
    .bad      (calc_bad)
  );

  agu_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .accept    (accept),
    .in_addr   (in_addr),
    .in_done   (in_done)
  );

  logic [AW-1:0]    addr_q, wbv_q;
  logic             wb_q, bad_q, store_q;
  logic [SEL_W-1:0] sel_q;

  // Request results captured once, on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wbv_q   <= '0;
      wb_q    <= 1'b0;
      bad_q   <= 1'b0;
      store_q <= 1'b0;
      sel_q   <= '0;
    end else if (accept) begin
      addr_q  <= calc_addr;
      wbv_q   <= calc_wbv;
      wb_q    <= calc_wb;
      bad_q   <= calc_bad;
      store_q <= req_store;
      sel_q   <= req_ptr_sel;
    end
  end

  assign mem_strobe = in_addr && !bad_q;
  assign mem_write  = mem_strobe && store_q;
  assign mem_addr   = addr_q;
  assign done       = in_done;
  assign illegal    = in_done && bad_q;
  assign wb_strobe  = in_done && wb_q;
  assign wb_sel     = sel_q;
  assign wb_value   = wbv_q;

endmodule

// File: rtl/lsu_ptr_agu_checker.sv
module lsu_ptr_agu_checker #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          req_ready,
  input logic          mem_strobe,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic          illegal,
  input logic          wb_strobe,
  input logic [AW-1:0] wb_value
);

  p_strobe_then_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_strobe |=> done);

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_strobe |=> $stable(mem_addr));

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  p_no_ready_in_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_strobe |-> !req_ready);

  p_wb_only_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_strobe |-> (done && !illegal));

  p_illegal_no_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> !$past(mem_strobe));

  p_wb_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_strobe |-> ((wb_value == mem_addr) || (wb_value == mem_addr + AW'(1))));

endmodule

bind lsu_ptr_agu lsu_ptr_agu_checker #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept     (accept),
  .req_ready  (req_ready),
  .mem_strobe (mem_strobe),
  .mem_addr   (mem_addr),
  .done       (done),
  .illegal    (illegal),
  .wb_strobe  (wb_strobe),
  .wb_value   (wb_value)
);

// File: tb/lsu_ptr_agu_tb_top.sv
`timescale 1ns/1ps
module lsu_ptr_agu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [1:0]  req_ptr_sel = '0;
  logic [2:0]  req_mode = '0;
  logic [5:0]  req_disp = '0;
  logic [15:0] req_direct = '0;
  logic [15:0] ptr_x = '0, ptr_y = '0, ptr_z = '0;
  logic        req_ready, mem_strobe, mem_write, done, illegal, wb_strobe;
  logic [15:0] mem_addr, wb_value;
  logic [1:0]  wb_sel;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  lsu_ptr_agu dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_ptr_sel(req_ptr_sel), .req_mode(req_mode), .req_disp(req_disp),
    .req_direct(req_direct), .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
    .req_ready(req_ready), .mem_strobe(mem_strobe), .mem_write(mem_write),
    .mem_addr(mem_addr), .done(done), .illegal(illegal), .wb_strobe(wb_strobe),
    .wb_sel(wb_sel), .wb_value(wb_value)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference model written from the requirements
  function automatic void model(input int m, input int s, input int p, input int q,
                                input int d, output bit ill, output int a,
                                output bit wb, output int wv);
    ill = 0; wb = 0; a = 0; wv = 0;
    if (m == 4) a = d;
    else if (m > 4 || s == 3) ill = 1;
    else if (m == 0) a = p;
    else if (m == 1) begin a = p; wb = 1; wv = (p + 1) % 65536; end
    else if (m == 2) begin a = (p + 65535) % 65536; wb = 1; wv = a; end
    else if (s == 0) ill = 1;
    else a = (p + q) % 65536;
  endfunction

  function automatic string tag_of(input int m, input bit ill);
    if (ill) return "R7";
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Called at a negedge; leaves at the negedge inside the completion cycle
  task automatic issue(input int s, input int m, input int q, input int d,
                       input bit st, input int px, input int py, input int pz,
                       input bit hold, input string tg);
    int p, a, wv;
    bit ill, wb;
    string t;
    p = (s == 0) ? px : (s == 1) ? py : (s == 2) ? pz : 0;
    model(m, s, p, q, d, ill, a, wb, wv);
    t = (tg == "") ? tag_of(m, ill) : tg;
    req_valid = 1'b1; req_store = st; req_ptr_sel = 2'(s); req_mode = 3'(m);
    req_disp = 6'(q); req_direct = 16'(d);
    ptr_x = 16'(px); ptr_y = 16'(py); ptr_z = 16'(pz);
    @(negedge clk);
    if (hold) begin
      // R10: a different request held during the access must be ignored
      req_mode = 3'd4; req_direct = 16'h5A5A; req_store = ~st;
    end else req_valid = 1'b0;
    check(t, "mem_strobe", int'(mem_strobe), int'(!ill));
    check("R10", "req_ready in access", int'(req_ready), 0);
    if (!ill) begin
      check(t, "mem_addr", int'(mem_addr), a);
      check("R11", "mem_write", int'(mem_write), int'(st));
    end
    @(negedge clk);
    req_valid = 1'b0;
    check("R9", "done", int'(done), 1);
    check(t, "illegal", int'(illegal), int'(ill));
    check(t, "wb_strobe", int'(wb_strobe), int'(wb));
    if (wb) begin
      check(t, "wb_value", int'(wb_value), wv);
      check("R12", "wb_sel", int'(wb_sel), s);
    end
  endtask

  task automatic expect_idle(input string tg);
    @(negedge clk);
    check(tg, "idle mem_strobe", int'(mem_strobe), 0);
    check(tg, "idle done", int'(done), 0);
    check(tg, "idle wb_strobe", int'(wb_strobe), 0);
    check(tg, "idle req_ready", int'(req_ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h2F71));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "req_ready", int'(req_ready), 1);
    check("R1", "mem_strobe", int'(mem_strobe), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "illegal", int'(illegal), 0);
    check("R1", "wb_strobe", int'(wb_strobe), 0);

    // Directed corners
    issue(1, 0, 0, 0, 0, 16'h1111, 16'h2222, 16'h3333, 0, "R2");
    issue(0, 1, 0, 0, 1, 16'hFFFF, 0, 0, 0, "R8");          // post-inc wrap
    issue(2, 2, 0, 0, 0, 0, 0, 16'h0000, 0, "R8");          // pre-dec wrap
    issue(2, 3, 63, 0, 0, 0, 0, 16'hFFFF, 0, "R8");         // disp wrap, q=63
    issue(1, 3, 0, 0, 1, 0, 16'h4000, 0, 0, "R5");          // q=0
    issue(0, 3, 5, 0, 0, 16'h0100, 0, 0, 0, "R7");          // disp on X
    issue(3, 1, 0, 0, 0, 1, 2, 3, 0, "R7");                 // no pointer
    issue(0, 6, 0, 0, 1, 1, 2, 3, 0, "R7");                 // spare mode
    issue(3, 4, 0, 16'hBEEF, 1, 0, 0, 0, 0, "R6");          // direct, sel 3
    issue(1, 2, 0, 0, 1, 0, 16'h8000, 0, 0, "R4");
    issue(2, 1, 0, 0, 0, 0, 0, 16'h1234, 0, "R3");
    expect_idle("R9");
    issue(1, 1, 0, 0, 0, 0, 16'h0042, 0, 1, "R10");
    expect_idle("R10");

    // Random mix, back to back
    for (int n = 0; n < 400; n++) begin
      int s, m;
      s = int'($urandom_range(3, 0));
      m = int'($urandom_range(7, 0));
      if ($urandom_range(3, 0) != 0) m = int'($urandom_range(4, 0));
      issue(s, m, int'($urandom_range(63, 0)), int'($urandom_range(65535, 0)),
            1'($urandom_range(1, 0)), int'($urandom_range(65535, 0)),
            int'($urandom_range(65535, 0)), int'($urandom_range(65535, 0)),
            1'($urandom_range(7, 0) == 0), "");
      if (n % 17 == 0) expect_idle("R9");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule